// File: doc/BRIEF.md
# Hot-Plug and Port Sideband Controller

This block is the low-speed side of a three-input video switch. It watches the connector 5V-present line of each input port and raises an interrupt when a cable goes in or comes out. It routes the downstream sink's hot-plug level to the input ports, or lets software set each port's hot-plug line directly. It also forms the digital enables for per-port input termination and for the main high-speed outputs.

The cable-presence lines come from the connectors and are not tied to the clock. They pass through synchronizer chains. Either edge of any of them sets a sticky interrupt flag, and a read strobe from the register interface clears it. Each hot-plug output has a line level and a drive enable. In open-drain mode only a low level is driven. In push-pull buffer mode the level is inverted, because an external transistor stage inverts it again. The select, mode, enable and termination fields come in as plain inputs from a register file that lives outside this block.

Top module: `hpd_sideband_ctrl`

## Requirements
- R1: `cable_status_o` gives the synchronized level of each presence input, with bit 0 for port A, bit 1 for port B and bit 2 for port C. A change at the input shows up after the second rising clock edge, and not after the first.
- R2: `int_flag_o` is 0 after reset. A rising or falling transition on any presence input sets it to 1 at the third rising clock edge after the input changes.
- R3: Once set, the flag stays at 1 until `flag_clr_i` is high at a clock edge. After that edge the flag reads 0.
- R4: If a presence transition reaches the flag logic in the same cycle as `flag_clr_i`, the flag ends at 1.
- R5: `intr_pull_low_o` is 1, pulling the interrupt pin low, while the flag is 0. It is 0, releasing the pin, while the flag is 1.
- R6: With `reg_hpd_src_i`=0 (sink source) and `reg_hpd_buf_i`=0 (open drain), the selected port's `hpd_o` equals `sink_hpd_i` and the other ports are 0. The `reg_port_sel_i` codes are 0 for A, 1 for B, 2 for C and 3 for none. With code 3 all three ports are 0.
- R7: With sink source and `reg_hpd_buf_i`=1 (buffer), the selected port outputs the inverse of `sink_hpd_i` and the other ports output 1. With code 3 all three ports output 1.
- R8: With `reg_hpd_src_i`=1, `hpd_o[i]` equals `reg_hpd_bits_i[i]` in open-drain mode and its inverse in buffer mode, whatever the port select is.
- R9: In open-drain mode `hpd_oe_o[i]` is 1 only when `hpd_o[i]` is 0: a 0 is driven low and a 1 is released. In buffer mode every `hpd_oe_o` bit is 1.
- R10: `main_out_en_o` is 1 only when `oe_n_i` is 0 and `reg_out_en_i` is 1.
- R11: `term_en_o[i]` is 1 only when `reg_term_en_i[i]` is 1 and `oe_n_i` is 0. Otherwise that port's pull-down is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sideband clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cable_5v_i | input | NPORT | Connector 5V-present lines, asynchronous |
| sink_hpd_i | input | 1 | Hot-plug level from the downstream sink |
| oe_n_i | input | 1 | Active-low output-enable pin |
| reg_port_sel_i | input | SEL_W | Selected input port; NPORT or above means none |
| reg_out_en_i | input | 1 | Register enable for the main outputs |
| reg_hpd_src_i | input | 1 | Hot-plug source: 0 sink, 1 register bits |
| reg_hpd_buf_i | input | 1 | Hot-plug output stage: 0 open drain, 1 buffer |
| reg_hpd_bits_i | input | NPORT | Per-port hot-plug levels set by software |
| reg_term_en_i | input | NPORT | Per-port termination request |
| flag_clr_i | input | 1 | Clear strobe issued when the status register is read |
| hpd_o | output | NPORT | Per-port hot-plug line level |
| hpd_oe_o | output | NPORT | Per-port hot-plug drive enable |
| int_flag_o | output | 1 | Sticky plug-event flag |
| intr_pull_low_o | output | 1 | Open-drain interrupt pin pull-down enable |
| cable_status_o | output | NPORT | Synchronized presence levels |
| term_en_o | output | NPORT | Per-port termination connect enable |
| main_out_en_o | output | 1 | High-speed output enable |

## Verification
The bench counts clock edges after each presence change. A synchronizer that is one stage too short or too long would show status or flag a cycle early or late. Falling edges are tested as well as rising ones, so a detector that only sees plug-in events would miss the unplug interrupt. The case where a transition and a clear strobe arrive in the same cycle is forced, to catch a flag that drops a new plug event. The routing vectors cover select code 3 in both output modes and register-source mode under a non-matching select, to catch designs that ignore the inversion or let the select leak into register mode.

// File: rtl/hpd_sb_pkg.sv
// Shared encodings for the sideband controller.
// Assumes: mode fields arrive as single bits from an external register file.
package hpd_sb_pkg;
    typedef enum logic {HPD_FROM_SINK = 1'b0, HPD_FROM_REG = 1'b1} hpd_src_e;
    typedef enum logic {STAGE_OPEN_DRAIN = 1'b0, STAGE_PUSH_PULL = 1'b1} hpd_stage_e;
endpackage

// File: rtl/cable_sync_edge.sv
// Synchronizes one asynchronous presence line and flags any change of it.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module cable_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic toggle_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw line through the chain and keep the previous synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // Either edge of the synchronized level is a toggle.
    always_comb begin
        level_o  = chain_q[STAGES-1];
        toggle_o = chain_q[STAGES-1] ^ last_q;
    end
endmodule

// File: rtl/intr_flag.sv
// Sticky interrupt flag: set by any plug event, cleared by a read strobe.
// Assumes: a set and a clear in the same cycle resolve to set.
module intr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/hpd_router.sv
// Routes sink or register hot-plug levels to each port and forms drive enables.
// Assumes: select codes at or above NPORT mean that no port is selected.
module hpd_router
    import hpd_sb_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int SEL_W = 2
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic             src_i,
    input  logic             stage_i,
    input  logic [NPORT-1:0] bits_i,
    input  logic             sink_i,
    output logic [NPORT-1:0] level_o,
    output logic [NPORT-1:0] drive_o
);
    hpd_src_e   src;
    hpd_stage_e stage;

    // Decode the mode bits into their named encodings.
    always_comb begin
        src   = hpd_src_e'(src_i);
        stage = hpd_stage_e'(stage_i);
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic raw;
        // Pick the logical level, then apply the output-stage polarity and drive rule.
        always_comb begin
            if (src == HPD_FROM_REG) raw = bits_i[p];
            else                     raw = sink_i & (sel_i == SEL_W'(p));
            if (stage == STAGE_PUSH_PULL) begin
                level_o[p] = ~raw;
                drive_o[p] = 1'b1;
            end else begin
                level_o[p] = raw;
                drive_o[p] = ~raw;
            end
        end
    end
endmodule

// File: rtl/hpd_sideband_ctrl.sv
// Top of the sideband controller: presence sync, interrupt, hot-plug routing, enables.
// Assumes: cable_5v_i is asynchronous; every other input is synchronous to clk.
module hpd_sideband_ctrl #(
    parameter int NPORT       = 3,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NPORT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] cable_5v_i,
    input  logic             sink_hpd_i,
    input  logic             oe_n_i,
    input  logic [SEL_W-1:0] reg_port_sel_i,
    input  logic             reg_out_en_i,
    input  logic             reg_hpd_src_i,
    input  logic             reg_hpd_buf_i,
    input  logic [NPORT-1:0] reg_hpd_bits_i,
    input  logic [NPORT-1:0] reg_term_en_i,
    input  logic             flag_clr_i,
    output logic [NPORT-1:0] hpd_o,
    output logic [NPORT-1:0] hpd_oe_o,
    output logic             int_flag_o,
    output logic             intr_pull_low_o,
    output logic [NPORT-1:0] cable_status_o,
    output logic [NPORT-1:0] term_en_o,
    output logic             main_out_en_o
);
    logic [NPORT-1:0] toggles;

    for (genvar p = 0; p < NPORT; p++) begin : g_sync
        cable_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_i  (cable_5v_i[p]),
            .level_o  (cable_status_o[p]),
            .toggle_o (toggles[p])
        );
    end

    intr_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (|toggles),
        .clr_i  (flag_clr_i),
        .flag_o (int_flag_o)
    );

    hpd_router #(.NPORT(NPORT), .SEL_W(SEL_W)) u_route (
        .sel_i   (reg_port_sel_i),
        .src_i   (reg_hpd_src_i),
        .stage_i (reg_hpd_buf_i),
        .bits_i  (reg_hpd_bits_i),
        .sink_i  (sink_hpd_i),
        .level_o (hpd_o),
        .drive_o (hpd_oe_o)
    );

    // Interrupt pin pull-down and the enables gated by the output-enable pin.
    always_comb begin
        intr_pull_low_o = ~int_flag_o;
        main_out_en_o   = ~oe_n_i & reg_out_en_i;
        term_en_o       = reg_term_en_i & {NPORT{~oe_n_i}};
    end
endmodule

// File: rtl/hpd_sideband_chk.sv
// Property checker for the sideband controller, bound to every instance of the top.
// Assumes: it only observes ports and drives nothing.
module hpd_sideband_chk #(
    parameter int NPORT = 3,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             oe_n_i,
    input logic             reg_hpd_src_i,
    input logic             reg_hpd_buf_i,
    input logic             flag_clr_i,
    input logic [NPORT-1:0] hpd_o,
    input logic [NPORT-1:0] hpd_oe_o,
    input logic             int_flag_o,
    input logic             intr_pull_low_o,
    input logic [NPORT-1:0] cable_status_o,
    input logic [NPORT-1:0] term_en_o,
    input logic             main_out_en_o
);
    assert_flag_on_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cable_status_o != $past(cable_status_o)) |=> int_flag_o);

    assert_flag_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_flag_o) |-> $past(flag_clr_i));

    assert_pin_opposes_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        intr_pull_low_o != int_flag_o);

    assert_sink_od_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_hpd_src_i && !reg_hpd_buf_i) |-> $onehot0(hpd_o));

    assert_od_never_drives_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_hpd_buf_i |-> ((hpd_o & hpd_oe_o) == '0));

    assert_buffer_drives_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hpd_buf_i |-> (&hpd_oe_o));

    assert_pin_blocks_enables_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> (!main_out_en_o && term_en_o == '0));
endmodule

bind hpd_sideband_ctrl hpd_sideband_chk #(.NPORT(NPORT), .SEL_W(SEL_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .oe_n_i          (oe_n_i),
    .reg_hpd_src_i   (reg_hpd_src_i),
    .reg_hpd_buf_i   (reg_hpd_buf_i),
    .flag_clr_i      (flag_clr_i),
    .hpd_o           (hpd_o),
    .hpd_oe_o        (hpd_oe_o),
    .int_flag_o      (int_flag_o),
    .intr_pull_low_o (intr_pull_low_o),
    .cable_status_o  (cable_status_o),
    .term_en_o       (term_en_o),
    .main_out_en_o   (main_out_en_o)
);

// File: tb/sim_hpd_sideband_ctrl.sv
`timescale 1ns/1ps
module sim_hpd_sideband_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cable = '0;
    logic       sink = 1'b0, oe_n = 1'b0, out_en = 1'b0, src = 1'b0, bufm = 1'b0, clr = 1'b0;
    logic [1:0] sel = '0;
    logic [2:0] bits = '0, term = '0;
    logic [2:0] hpd, hpd_oe, status, term_en;
    logic       flag, pull_low, main_en;

    int applied = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    hpd_sideband_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cable_5v_i(cable), .sink_hpd_i(sink), .oe_n_i(oe_n),
        .reg_port_sel_i(sel), .reg_out_en_i(out_en), .reg_hpd_src_i(src),
        .reg_hpd_buf_i(bufm), .reg_hpd_bits_i(bits), .reg_term_en_i(term),
        .flag_clr_i(clr), .hpd_o(hpd), .hpd_oe_o(hpd_oe), .int_flag_o(flag),
        .intr_pull_low_o(pull_low), .cable_status_o(status), .term_en_o(term_en),
        .main_out_en_o(main_en)
    );

    // Vector fields: [13:12] sel, [11] src, [10] buffer, [9:7] bits (C,B,A), [6] sink,
    // [5:3] expected hpd (C,B,A), [2:0] expected drive enables (C,B,A).
    localparam int NV = 12;
    localparam logic [13:0] VECS [0:NV-1] = '{
        {2'd0, 1'b0, 1'b0, 3'b000, 1'b1, 3'b001, 3'b110},  // R6 port A
        {2'd1, 1'b0, 1'b0, 3'b000, 1'b1, 3'b010, 3'b101},  // R6 port B
        {2'd2, 1'b0, 1'b0, 3'b111, 1'b1, 3'b100, 3'b011},  // R6 port C, bits ignored
        {2'd0, 1'b0, 1'b0, 3'b000, 1'b0, 3'b000, 3'b111},  // R6 sink low
        {2'd3, 1'b0, 1'b0, 3'b000, 1'b1, 3'b000, 3'b111},  // R6 none selected
        {2'd0, 1'b0, 1'b1, 3'b000, 1'b1, 3'b110, 3'b111},  // R7 port A
        {2'd1, 1'b0, 1'b1, 3'b000, 1'b0, 3'b111, 3'b111},  // R7 port B sink low
        {2'd2, 1'b0, 1'b1, 3'b000, 1'b1, 3'b011, 3'b111},  // R7 port C
        {2'd3, 1'b0, 1'b1, 3'b000, 1'b1, 3'b111, 3'b111},  // R7 none selected
        {2'd1, 1'b1, 1'b0, 3'b101, 1'b1, 3'b101, 3'b010},  // R8 open drain
        {2'd3, 1'b1, 1'b1, 3'b101, 1'b0, 3'b010, 3'b111},  // R8 buffer
        {2'd0, 1'b1, 1'b0, 3'b010, 1'b0, 3'b010, 3'b101}   // R8 open drain, other select
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // Reset state: R2, R5, R1.
        check("R2 reset flag", flag, 0);
        check("R5 reset pin pulled low", pull_low, 1);
        check("R1 reset status", status, 0);

        // Routing table: R6, R7, R8, R9.
        for (int v = 0; v < NV; v++) begin
            sel = VECS[v][13:12]; src = VECS[v][11]; bufm = VECS[v][10];
            bits = VECS[v][9:7];  sink = VECS[v][6];
            #1;
            check("R6/R7/R8 hpd level", hpd, VECS[v][5:3]);
            check("R9 hpd drive", hpd_oe, VECS[v][2:0]);
        end

        // Enable gating over all pin, enable and termination values: R10, R11.
        for (int k = 0; k < 32; k++) begin
            oe_n = k[0]; out_en = k[1]; term = k[4:2];
            #1;
            check("R10 main enable", main_en, (!k[0] && k[1]) ? 1 : 0);
            check("R11 termination", term_en, k[0] ? 0 : k[4:2]);
        end

        // Plug on port B: status after two edges, flag after three (R1, R2).
        cable = 3'b010;
        step(1);
        check("R1 status not yet", status, 0);
        step(1);
        check("R1 status port B bit", status, 3'b010);
        check("R2 flag not yet", flag, 0);
        step(1);
        check("R2 flag set on rise", flag, 1);
        check("R5 pin released", pull_low, 0);
        step(4);
        check("R3 flag sticky", flag, 1);

        // Clear strobe (R3).
        clr = 1'b1; step(1); clr = 1'b0;
        check("R3 flag cleared", flag, 0);
        check("R5 pin low again", pull_low, 1);

        // Unplug is also an event (R2).
        cable = 3'b000;
        step(3);
        check("R2 flag set on fall", flag, 1);
        clr = 1'b1; step(1); clr = 1'b0;
        check("R3 flag cleared again", flag, 0);

        // Event and clear in the same cycle (R4).
        cable = 3'b100;
        step(2);
        check("R1 status port C bit", status, 3'b100);
        clr = 1'b1; step(1); clr = 1'b0;
        check("R4 set wins over clear", flag, 1);
        step(2);
        check("R4 flag held", flag, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end
endmodule